// File: doc/BRIEF.md
# Line Frame Decoder and Checker

This block sits behind a serial receiver's deserializer. On each clock where `in_valid` is high, it takes one 24-bit line frame. The frame holds a 20-bit payload field and a 4-bit coding field. The block decides whether the frame carries data, control or fill, or whether it is in error.

For data frames and control frames, the block removes the DC-balancing inversion and returns the original payload bits. For data frames it also returns the recovered flag bit. Disallowed frames are flagged before the result reaches the user. The block also reports whether the mandatory centre transition of the coding field was present.

An optional mode treats the flag bit as a toggling sequence marker. In that mode, two consecutive data frames that carry the same flag value are reported as an error. All results are registered, so each frame's result appears one clock after it is presented.

Top module: `ldec_frame_decoder`

## Requirements
- R1: Bit layout of a frame: the coding field is `in_frame[3:0]`, whose first line bit is `in_frame[3]`. The payload field is `in_frame[23:4]`, whose first line bit is `in_frame[23]`. Data frames are recognised by these coding values:

  | Coding field | Flag | Payload |
  |---|---|---|
  | 1101 | 0 | true form |
  | 0010 | 0 | complemented |
  | 1011 | 1 | true form |
  | 0100 | 1 | complemented |

  For a data frame, `out_word` is the payload with any complement undone.
- R2: Coding values 0011 and 1100 mark a control frame, and 1100 means the payload is complemented before extraction. After any complement, 18 control bits are taken from payload bits [19:12] and [9:0]. They are output as `{2'b00, p[19:12], p[9:0]}`.
- R3: The block recognises three exact fill frames:
  - 24'hFFC003 reports as fill 0.
  - 24'hFFE003 reports as fill 1.
  - 24'hFF8003 also reports as fill 1.

  Fill frames are not errors, and for a fill frame `out_word` is 0.
- R4: A frame whose coding-field centre bits `in_frame[2:1]` are equal is an error, and `out_mt_ok` is 0 for it. For every frame, `out_mt_ok` is 1 exactly when those two bits differ.
- R5: Coding values 1010 and 0101 are errors.
- R6: A control frame whose payload bits [11:10] are not 01 after any complement is an error, unless it is an exact fill frame.
- R7: While `flag_toggle_en` is 1, a data frame whose flag equals the flag of the previous data frame is an error. This only applies if that previous data frame also arrived while the mode was on. Clearing `flag_toggle_en` forgets the history.
- R8: Each result appears on the clock after `in_valid`, and `out_valid` marks it. When `in_valid` is 0, `out_valid` is 0 and the other outputs hold their values.
- R9: Reset is asynchronous and active-low. While reset is low, all outputs are 0.
- R10: The frame type codes are DATA=0, CTRL=1, FILL0=2, FILL1=3, ERROR=4. `out_err` is 1 exactly for ERROR. ERROR frames output word 0. `out_flag` is 0 for every type other than DATA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A frame is present on `in_frame` |
| in_frame | input | 24 | Deserialized line frame |
| flag_toggle_en | input | 1 | Enables the alternating-flag check |
| out_valid | output | 1 | Result of the previous clock's frame is valid |
| out_word | output | 20 | Restored data word or control bits |
| out_flag | output | 1 | Recovered flag bit of a data frame |
| out_type | output | 3 | Frame type code |
| out_err | output | 1 | Frame is in error |
| out_mt_ok | output | 1 | Centre transition was present |

## Verification
Several properties are checked by assertions on every cycle:
- frames that lack a centre transition, and the two forbidden alternating coding values, always produce an error on the next clock;
- the valid flag follows its input with one clock of delay;
- outputs stay frozen on idle clocks;
- control words keep their top two bits at zero;
- non-data results never carry a flag.

Some behaviour can only be shown by the bench's scenarios. This covers the exact values of restored data and control words, fill recognition against near-miss patterns, the fixed-pair check, and the history-dependent toggle check across mode changes.

// File: rtl/ldec_pkg.sv
package ldec_pkg;

  typedef enum logic [2:0] {
    FT_DATA  = 3'd0,
    FT_CTRL  = 3'd1,
    FT_FILL0 = 3'd2,
    FT_FILL1 = 3'd3,
    FT_ERR   = 3'd4
  } ftype_e;

  localparam int CF_W = 4;

endpackage

// File: rtl/ldec_cfield.sv
module ldec_cfield (
  input  logic [3:0] cfield,
  output logic       is_data,
  output logic       is_ctrl,
  output logic       invert,
  output logic       flag,
  output logic       mt_ok
);

  always_comb begin
    is_data = 1'b0;
    is_ctrl = 1'b0;
    invert  = 1'b0;
    flag    = 1'b0;
    unique case (cfield)
      4'b1101: begin is_data = 1'b1; end
      4'b0010: begin is_data = 1'b1; invert = 1'b1; end
      4'b1011: begin is_data = 1'b1; flag = 1'b1; end
      4'b0100: begin is_data = 1'b1; flag = 1'b1; invert = 1'b1; end
      4'b0011: begin is_ctrl = 1'b1; end
      4'b1100: begin is_ctrl = 1'b1; invert = 1'b1; end
      default: ;
    endcase
    mt_ok = cfield[2] ^ cfield[1];
  end

endmodule

// File: rtl/ldec_fill.sv
module ldec_fill #(
  parameter int DATA_W = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DATA_W+3:0]     frame,
  output logic                  is_fill0,
  output logic                  is_fill1
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int HALF    = DATA_W / 2;

  function automatic logic [FRAME_W-1:0] mk_fill(input int ones);
    logic [FRAME_W-1:0] p;
    p = '0;
    for (int i = 0; i < DATA_W; i++) begin
      p[FRAME_W-1-i] = (i < ones);
    end
    p[3:0] = 4'b0011;
    return p;
  endfunction

  localparam logic [FRAME_W-1:0] FILL0  = mk_fill(HALF);
  localparam logic [FRAME_W-1:0] FILL1A = mk_fill(HALF + 1);
  localparam logic [FRAME_W-1:0] FILL1B = mk_fill(HALF - 1);

  assign is_fill0 = (frame == FILL0);
  assign is_fill1 = (frame == FILL1A) || (frame == FILL1B);

  p_fill_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_fill0 && is_fill1));

endmodule

// File: rtl/ldec_flag_trk.sv
module ldec_flag_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle_en,
  input  logic chk_en,
  input  logic flag,
  output logic viol
);

  logic have_prev_q, have_prev_d;
  logic prev_flag_q, prev_flag_d;

  always_comb begin
    have_prev_d = have_prev_q;
    prev_flag_d = prev_flag_q;
    if (!toggle_en) begin
      have_prev_d = 1'b0;
    end else if (chk_en) begin
      have_prev_d = 1'b1;
      prev_flag_d = flag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      prev_flag_q <= 1'b0;
    end else begin
      have_prev_q <= have_prev_d;
      prev_flag_q <= prev_flag_d;
    end
  end

  assign viol = chk_en & toggle_en & have_prev_q & (flag == prev_flag_q);

  // R7: no history survives a cleared mode
  p_hist_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !toggle_en |=> !have_prev_q);

endmodule

// File: rtl/ldec_frame_decoder.sv
module ldec_frame_decoder
  import ldec_pkg::*;
#(
  parameter int DATA_W  = 20,
  parameter int CTRL_HI = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [DATA_W+3:0]   in_frame,
  input  logic                flag_toggle_en,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_word,
  output logic                out_flag,
  output logic [2:0]          out_type,
  output logic                out_err,
  output logic                out_mt_ok
);

  localparam int FRAME_W  = DATA_W + CF_W;
  localparam int PAIR_LSB = DATA_W - CTRL_HI - 2;

  logic [DATA_W-1:0] dfield, dcorr, ctrl_word;
  logic [CF_W-1:0]   cfield;
  logic              is_data, is_ctrl, invert, cf_flag, mt_ok;
  logic              is_fill0, is_fill1, pair_ok, viol;

  ftype_e            nxt_type;
  logic [DATA_W-1:0] nxt_word;
  logic              nxt_flag;

  assign dfield = in_frame[FRAME_W-1:CF_W];
  assign cfield = in_frame[CF_W-1:0];

  ldec_cfield u_cf (
    .cfield  (cfield),
    .is_data (is_data),
    .is_ctrl (is_ctrl),
    .invert  (invert),
    .flag    (cf_flag),
    .mt_ok   (mt_ok)
  );

  ldec_fill #(.DATA_W(DATA_W)) u_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame    (in_frame),
    .is_fill0 (is_fill0),
    .is_fill1 (is_fill1)
  );

  ldec_flag_trk u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .toggle_en (flag_toggle_en),
    .chk_en    (in_valid & is_data),
    .flag      (cf_flag),
    .viol      (viol)
  );

  assign dcorr     = dfield ^ {DATA_W{invert}};
  assign pair_ok   = (dcorr[PAIR_LSB+1:PAIR_LSB] == 2'b01);
  assign ctrl_word = {2'b00, dcorr[DATA_W-1 -: CTRL_HI], dcorr[PAIR_LSB-1:0]};

  always_comb begin
    nxt_type = FT_ERR;
    nxt_word = '0;
    nxt_flag = 1'b0;
    if (is_fill0) begin
      nxt_type = FT_FILL0;
    end else if (is_fill1) begin
      nxt_type = FT_FILL1;
    end else if (is_data && !viol) begin
      nxt_type = FT_DATA;
      nxt_word = dcorr;
      nxt_flag = cf_flag;
    end else if (is_ctrl && pair_ok) begin
      nxt_type = FT_CTRL;
      nxt_word = ctrl_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_flag  <= 1'b0;
      out_type  <= 3'd0;
      out_err   <= 1'b0;
      out_mt_ok <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word  <= nxt_word;
        out_flag  <= nxt_flag;
        out_type  <= nxt_type;
        out_err   <= (nxt_type == FT_ERR);
        out_mt_ok <= mt_ok;
      end
    end
  end

  p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_word) && $stable(out_type) && $stable(out_err)));
  p_no_mt_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_frame[2] == in_frame[1])) |=> (out_err && !out_mt_ok));
  p_alt_code_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ((cfield == 4'b1010) || (cfield == 4'b0101))) |=> out_err);
  p_ctrl_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_type == FT_CTRL)) |-> (out_word[DATA_W-1 -: 2] == 2'b00));
  p_flag_nondata_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_type != FT_DATA)) |-> !out_flag);

endmodule

// File: tb/ldec_frame_decoder_tb.sv
`timescale 1ns/1ps
module ldec_frame_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [23:0] in_frame;
  logic        flag_toggle_en;
  logic        out_valid;
  logic [19:0] out_word;
  logic        out_flag;
  logic [2:0]  out_type;
  logic        out_err;
  logic        out_mt_ok;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // model state and expected outputs
  bit          m_hp;
  bit          m_pf;
  logic [19:0] e_word;
  logic        e_flag;
  logic [2:0]  e_type;
  logic        e_mt;

  localparam logic [23:0] F0  = 24'hFFC003;
  localparam logic [23:0] F1A = 24'hFFE003;
  localparam logic [23:0] F1B = 24'hFF8003;

  always #2 clk = ~clk;

  ldec_frame_decoder u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_frame       (in_frame),
    .flag_toggle_en (flag_toggle_en),
    .out_valid      (out_valid),
    .out_word       (out_word),
    .out_flag       (out_flag),
    .out_type       (out_type),
    .out_err        (out_err),
    .out_mt_ok      (out_mt_ok)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected decode from the requirements
  task automatic model(input logic [23:0] f, input bit tog, output bit is_dat, output bit fl);
    logic [3:0]  c;
    logic [19:0] d;
    c = f[3:0];
    d = f[23:4];
    is_dat = 0;
    fl = 0;
    e_word = 20'h0;
    e_flag = 1'b0;
    e_type = 3'd4;
    e_mt = c[2] ^ c[1];
    if (f == F0) e_type = 3'd2;
    else if (f == F1A || f == F1B) e_type = 3'd3;
    else begin
      case (c)
        4'b1101, 4'b0010, 4'b1011, 4'b0100: begin
          is_dat = 1;
          fl = (c == 4'b1011 || c == 4'b0100);
          if (!(tog && m_hp && fl == m_pf)) begin
            e_type = 3'd0;
            e_flag = fl;
            e_word = (c == 4'b0010 || c == 4'b0100) ? ~d : d;
          end
        end
        4'b0011, 4'b1100: begin
          if (c == 4'b1100) d = ~d;
          if (d[11:10] == 2'b01) begin
            e_type = 3'd1;
            e_word = {2'b00, d[19:12], d[9:0]};
          end
        end
        default: ;
      endcase
    end
  endtask

  task automatic step(input bit v, input logic [23:0] f, input bit tog, input string req);
    bit is_dat, fl;
    @(negedge clk);
    in_valid = v;
    in_frame = f;
    flag_toggle_en = tog;
    if (v) model(f, tog, is_dat, fl);
    else begin is_dat = 0; fl = 0; end
    if (!tog) m_hp = 0;
    else if (v && is_dat) begin m_hp = 1; m_pf = fl; end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "valid", out_valid, v);
    chk(req, "word", out_word, e_word);
    chk(req, "flag", out_flag, e_flag);
    chk(req, "type", out_type, e_type);
    chk(req, "err", out_err, (e_type == 3'd4));
    chk(req, "mt_ok", out_mt_ok, e_mt);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [19:0] rd;
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_frame = '0;
    flag_toggle_en = 1'b0;
    m_hp = 0;
    m_pf = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk("R9", "valid", out_valid, 0);
    chk("R9", "word", out_word, 0);
    chk("R9", "type", out_type, 0);
    chk("R9", "err", out_err, 0);
    chk("R9", "mt_ok", out_mt_ok, 0);
    rst_n = 1'b1;
    e_word = '0; e_flag = 0; e_type = 0; e_mt = 0;

    // R1: data codes
    step(1, {20'hA5C3E, 4'b1101}, 0, "R1");
    step(1, {20'hA5C3E, 4'b0010}, 0, "R1");
    step(1, {20'h1234F, 4'b1011}, 0, "R1");
    step(1, {20'h1234F, 4'b0100}, 0, "R1");
    // R2 good control, R6 bad pair
    step(1, {8'hC7, 2'b01, 10'h2A5, 4'b0011}, 0, "R2");
    step(1, {8'h38, 2'b10, 10'h15A, 4'b1100}, 0, "R2");
    step(1, {8'hC7, 2'b11, 10'h2A5, 4'b0011}, 0, "R6");
    step(1, {8'h38, 2'b01, 10'h15A, 4'b1100}, 0, "R6");
    // R3 fills and a near miss
    step(1, F0, 0, "R3");
    step(1, F1A, 0, "R3");
    step(1, F1B, 0, "R3");
    step(1, F0 ^ 24'h000010, 0, "R3");
    // R4 centre equal, R5 alternating codes
    step(1, {20'hFFFFF, 4'b0000}, 0, "R4");
    step(1, {20'h00000, 4'b1111}, 0, "R4");
    step(1, {20'h0F0F0, 4'b0110}, 0, "R4");
    step(1, {20'h0F0F0, 4'b1001}, 0, "R4");
    step(1, {20'h13579, 4'b1010}, 0, "R5");
    step(1, {20'h13579, 4'b0101}, 0, "R5");
    // R8 idle hold
    step(0, {20'h55555, 4'b1101}, 0, "R8");
    step(0, 24'h0, 0, "R8");
    // R7 toggle mode
    step(1, {20'h00001, 4'b1101}, 1, "R7");
    step(1, {20'h00002, 4'b1011}, 1, "R7");
    step(1, F1A, 1, "R7");
    step(1, {20'h00003, 4'b0100}, 1, "R7");
    step(1, {20'h00004, 4'b0010}, 1, "R7");
    step(0, 24'h0, 0, "R7");
    step(1, {20'h00005, 4'b0010}, 1, "R7");
    step(1, {20'h00006, 4'b1101}, 1, "R7");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit tog;
      bit v;
      int k;
      logic [23:0] f;
      tog = ($urandom % 8) != 0;
      v = ($urandom % 6) != 0;
      k = $urandom % 10;
      rd = 20'($urandom);
      case (k)
        0: f = 24'($urandom);
        1: f = (($urandom % 2) != 0) ? F0 : ((($urandom % 2) != 0) ? F1A : F1B);
        2, 3: f = {8'(rd[19:12]), 2'b01, rd[9:0], 4'b0011};
        4: f = {8'(rd[19:12]), 2'b10, rd[9:0], 4'b1100};
        5: f = {rd, 4'($urandom)};
        default: begin
          case ($urandom % 4)
            0: f = {rd, 4'b1101};
            1: f = {rd, 4'b0010};
            2: f = {rd, 4'b1011};
            default: f = {rd, 4'b0100};
          endcase
        end
      endcase
      step(v, f, tog, "R10");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule